// File: doc/BRIEF.md
# Channel Block Framer

This block takes the sample stream of a single receiver channel and cuts it into blocks of `BLOCK_LEN` samples. Every block leaves the block as one header word and then its samples. The header names the channel, carries a block sequence number and the time tag of the block's first sample, and says where the first flagged sample sits inside the block. Payload samples wait in an elastic buffer. Occupancy threshold flags and a peak-occupancy register describe how full that buffer is.

The input side has no ready signal, because the upstream sample source cannot pause. If the buffer lacks room for a whole block when that block's first sample arrives, the block is discarded in full. The sequence counter still moves on, so the consumer sees a gap in the numbers. A saturating discard counter and an overflow flag make every loss visible.

The output is a valid/ready stream with the following back-pressure rules:
- Once `out_valid` is high, it stays high and `out_data` stays unchanged until `out_ready` accepts the word.
- A header is offered only after its whole block has been buffered, so the payload never pauses from the producer's side.
- `out_first` marks the header and `out_last` marks the final sample.

Top module: `chan_block_framer`

## Requirements
- R1: While reset is held and just after it: `out_valid` is low, `drop_cnt` is 0, `overflow` is low, `peak_occ` is 0 and `lvl_low` is high.
- R2: Framing of an admitted block:
  - It is emitted as one header word with `out_first` high, then `BLOCK_LEN` payload words with `out_first` low.
  - Each payload word holds the sample in bits [SAMPLE_W-1:0], and its upper bits are zero.
  - `out_last` is high only on the last payload word.
  - The header is offered only after every sample of its block is buffered.
- R3: Header bit fields (defaults: 33-bit word):
  - Channel id in bits [32:29], taken at the block's first sample.
  - Sequence number in bits [28:21].
  - Time tag of the block's first sample in bits [20:5].
- R4: Marker fields of the header:
  - Bits [4:2] hold the position (0 to BLOCK_LEN-1, counted in valid samples) of the first sample flagged by `in_marker`, or 0 if no sample was flagged.
  - Bit 1 is set when at least one sample was flagged.
  - Bit 0 is set when two or more samples were flagged.
- R5: A block is admitted only if buffer occupancy is at most FIFO_DEPTH-BLOCK_LEN in the cycle of its first sample. Otherwise none of its samples and no header for it ever appear at the output.
- R6: Sequence number and discard count:
  - The sequence number increases by one for every block start, admitted or discarded, and wraps modulo 2^SEQ_W.
  - `drop_cnt` increases by one for every discarded block and holds at all ones.
- R7: `overflow` rises in the cycle after the first sample of a discarded block. It stays high until the cycle after the first sample of the next admitted block.
- R8: Occupancy is the number of payload words stored. The threshold flags are:
  - `lvl_low` = occupancy < LOW_TH
  - `lvl_mid` = occupancy >= MID_TH
  - `lvl_high` = occupancy >= HIGH_TH
- R9: Each cycle, `peak_occ` becomes the larger of itself and the previous cycle's occupancy. In a cycle with `stat_clr` high, it loads that occupancy instead.
- R10: Once `out_valid` is high, it stays high and `out_data` is held until a cycle with `out_ready` high.
- R11: `stat_clr` zeroes `drop_cnt`. A discard in the same cycle is still counted and leaves `drop_cnt` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_clr | input | 1 | One-cycle pulse that clears the discard count and restarts the peak |
| chan_id | input | CHAN_W | Channel number placed in headers |
| in_valid | input | 1 | A sample is present this cycle |
| in_sample | input | SAMPLE_W | Sample value |
| in_marker | input | 1 | Flags this sample as a marker |
| in_tag | input | TAG_W | Time tag of this sample |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | WORD_W | Header or payload word |
| out_first | output | 1 | Current word is a header |
| out_last | output | 1 | Current word is the last payload word |
| drop_cnt | output | DROP_W | Saturating count of discarded blocks |
| overflow | output | 1 | High over a discard interval |
| lvl_low | output | 1 | Occupancy below low threshold |
| lvl_mid | output | 1 | Occupancy at or above middle threshold |
| lvl_high | output | 1 | Occupancy at or above high threshold |
| peak_occ | output | CW | Highest occupancy seen since reset or clear |

## Verification
The bench targets the corner cases below:
- The admission limit when occupancy sits exactly at FIFO_DEPTH-BLOCK_LEN. A design that compares against the full depth would admit a block that cannot fit, and payload would be corrupted.
- Markers on the first sample, on the last sample, and twice in one block. A design that latches the last marker, or that forgets a marker on the final sample, shows the wrong offset or flag bits in the header.
- Discards that must leave a gap in the sequence numbers. A design that advances the number only on admission hides the loss.
- A clear pulse in the same cycle as a discard, and saturation of the counter after hundreds of discards. A design that wraps or drops that count would report too few losses.

// File: rtl/blkfr_pkg.sv
package blkfr_pkg;

  // Egress phase: a header word is pending, or a payload run is in progress.
  typedef enum logic {
    PH_HEAD = 1'b0,
    PH_BODY = 1'b1
  } egress_ph_t;

  // Index width that stays at least one bit for a count of one.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/blkfr_fifo.sv
module blkfr_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  localparam int PW = blkfr_pkg::idx_w(DEPTH);
  localparam logic [PW-1:0] TOP = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == TOP) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= step(wptr);
      if (pop)  rptr <= step(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH)) || pop);  // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);  // R2

endmodule

// File: rtl/blkfr_ingest.sv
module blkfr_ingest #(
  parameter int SAMPLE_W  = 16,
  parameter int TAG_W     = 16,
  parameter int CHAN_W    = 4,
  parameter int SEQ_W     = 8,
  parameter int DROP_W    = 8,
  parameter int BLOCK_LEN = 8,
  parameter int DEPTH     = 32,
  localparam int OFF_W    = blkfr_pkg::idx_w(BLOCK_LEN),
  localparam int HDR_W    = CHAN_W + SEQ_W + TAG_W + OFF_W + 2,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stat_clr,
  input  logic [CHAN_W-1:0]   chan_id,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                in_marker,
  input  logic [TAG_W-1:0]    in_tag,
  input  logic [CW-1:0]       occ,
  output logic                wr_en,
  output logic [SAMPLE_W-1:0] wr_data,
  output logic                hdr_push,
  output logic [HDR_W-1:0]    hdr_word,
  output logic [DROP_W-1:0]   drop_cnt,
  output logic                overflow
);
  localparam logic [OFF_W-1:0]  LAST = OFF_W'(BLOCK_LEN - 1);
  localparam int                ROOM = DEPTH - BLOCK_LEN;
  localparam logic [DROP_W-1:0] DMAX = '1;

  logic [OFF_W-1:0]  pos;
  logic              keep;
  logic              dropping;
  logic [SEQ_W-1:0]  seq_ctr, seq_cur;
  logic [TAG_W-1:0]  tag_cur;
  logic [CHAN_W-1:0] chan_cur;
  logic              mk_seen, mk_multi;
  logic [OFF_W-1:0]  mk_off;

  logic              start, room_ok, drop_evt;
  logic              fin_seen, fin_multi;
  logic [OFF_W-1:0]  fin_off;
  logic [DROP_W-1:0] drop_base;

  assign start    = in_valid && (pos == '0);
  assign room_ok  = occ <= CW'(ROOM);
  assign drop_evt = start && !room_ok;

  assign wr_en    = in_valid && (start ? room_ok : keep);
  assign wr_data  = in_sample;
  assign hdr_push = in_valid && (pos == LAST) && keep && !start;

  // Fold the final sample's marker into the header being closed.
  assign fin_seen  = mk_seen | in_marker;
  assign fin_multi = mk_multi | (mk_seen & in_marker);
  assign fin_off   = mk_seen ? mk_off : (in_marker ? LAST : '0);
  assign hdr_word  = {chan_cur, seq_cur, tag_cur, fin_off, fin_seen, fin_multi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      keep     <= 1'b0;
      dropping <= 1'b0;
      seq_ctr  <= '0;
      seq_cur  <= '0;
      tag_cur  <= '0;
      chan_cur <= '0;
      mk_seen  <= 1'b0;
      mk_multi <= 1'b0;
      mk_off   <= '0;
    end else if (in_valid) begin
      pos <= (pos == LAST) ? '0 : pos + 1'b1;
      if (start) begin
        keep     <= room_ok;
        dropping <= !room_ok;
        seq_cur  <= seq_ctr;
        seq_ctr  <= seq_ctr + 1'b1;
        tag_cur  <= in_tag;
        chan_cur <= chan_id;
        mk_seen  <= in_marker;
        mk_multi <= 1'b0;
        mk_off   <= '0;
      end else if (in_marker) begin
        if (mk_seen) begin
          mk_multi <= 1'b1;
        end else begin
          mk_seen <= 1'b1;
          mk_off  <= pos;
        end
      end
    end
  end

  // Discard counter: a clear and a discard in one cycle leave a count of one.
  assign drop_base = stat_clr ? '0 : drop_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_cnt <= '0;
    else if (drop_evt && drop_base != DMAX) drop_cnt <= drop_base + 1'b1;
    else drop_cnt <= drop_base;
  end

  assign overflow = dropping;

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + 1'b1));  // R6
  AST_MULTI_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    mk_multi |-> mk_seen);  // R4
  AST_NO_WRITE_WHILE_DROPPING: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !start && overflow) |-> !wr_en);  // R5

endmodule

// File: rtl/blkfr_levels.sv
module blkfr_levels #(
  parameter int DEPTH   = 32,
  parameter int LOW_TH  = 8,
  parameter int MID_TH  = 16,
  parameter int HIGH_TH = 24,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] occ,
  output logic          lvl_low,
  output logic          lvl_mid,
  output logic          lvl_high,
  output logic [CW-1:0] peak
);
  localparam int NTH = 3;
  localparam int TH [NTH] = '{LOW_TH, MID_TH, HIGH_TH};

  logic [NTH-1:0] reached;

  for (genvar g = 0; g < NTH; g++) begin : g_cmp
    assign reached[g] = occ >= CW'(TH[g]);
  end

  assign lvl_low  = !reached[0];
  assign lvl_mid  = reached[1];
  assign lvl_high = reached[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          peak <= '0;
    else if (clr)        peak <= occ;
    else if (occ > peak) peak <= occ;
  end

  AST_PEAK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> peak >= $past(peak));  // R9
  AST_PEAK_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> peak >= $past(occ));  // R9
  AST_LVL_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_high |-> lvl_mid);  // R8

endmodule

// File: rtl/blkfr_egress.sv
module blkfr_egress #(
  parameter int BLOCK_LEN = 8,
  parameter int SAMPLE_W  = 16,
  parameter int HDR_W     = 33
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hdr_avail,
  input  logic [HDR_W-1:0]    hdr_word,
  input  logic                data_avail,
  input  logic [SAMPLE_W-1:0] data_word,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [HDR_W-1:0]    out_data,
  output logic                out_first,
  output logic                out_last,
  output logic                hdr_pop,
  output logic                data_pop
);
  import blkfr_pkg::*;

  localparam int OFF_W = idx_w(BLOCK_LEN);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(BLOCK_LEN - 1);

  egress_ph_t       phase;
  logic [OFF_W-1:0] beat;
  logic             fire;

  assign out_valid = (phase == PH_BODY) ? data_avail : hdr_avail;
  assign out_data  = (phase == PH_BODY) ? HDR_W'(data_word) : hdr_word;
  assign out_first = (phase == PH_HEAD);
  assign out_last  = (phase == PH_BODY) && (beat == LAST);

  assign fire     = out_valid && out_ready;
  assign hdr_pop  = fire && (phase == PH_HEAD);
  assign data_pop = fire && (phase == PH_BODY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_HEAD;
      beat  <= '0;
    end else if (hdr_pop) begin
      phase <= PH_BODY;
      beat  <= '0;
    end else if (data_pop) begin
      if (beat == LAST) phase <= PH_HEAD;
      else              beat  <= beat + 1'b1;
    end
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);  // R10
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data));  // R10
  AST_BODY_FED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BODY) |-> data_avail);  // R2

endmodule

// File: rtl/chan_block_framer.sv
module chan_block_framer #(
  parameter int SAMPLE_W   = 16,
  parameter int TAG_W      = 16,
  parameter int CHAN_W     = 4,
  parameter int SEQ_W      = 8,
  parameter int DROP_W     = 8,
  parameter int BLOCK_LEN  = 8,
  parameter int FIFO_DEPTH = 32,
  parameter int LOW_TH     = 8,
  parameter int MID_TH     = 16,
  parameter int HIGH_TH    = 24,
  localparam int OFF_W     = blkfr_pkg::idx_w(BLOCK_LEN),
  localparam int WORD_W    = CHAN_W + SEQ_W + TAG_W + OFF_W + 2,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stat_clr,
  input  logic [CHAN_W-1:0]   chan_id,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                in_marker,
  input  logic [TAG_W-1:0]    in_tag,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_data,
  output logic                out_first,
  output logic                out_last,
  output logic [DROP_W-1:0]   drop_cnt,
  output logic                overflow,
  output logic                lvl_low,
  output logic                lvl_mid,
  output logic                lvl_high,
  output logic [CW-1:0]       peak_occ
);
  // One header per whole block that can fit in the payload buffer.
  localparam int HDR_DEPTH = FIFO_DEPTH / BLOCK_LEN;
  localparam int HCW       = $clog2(HDR_DEPTH + 1);

  logic                wr_en, data_pop, hdr_push, hdr_pop;
  logic [SAMPLE_W-1:0] wr_data, data_head;
  logic [WORD_W-1:0]   hdr_word, hdr_head;
  logic [CW-1:0]       occ;
  logic [HCW-1:0]      hcount;

  blkfr_ingest #(
    .SAMPLE_W(SAMPLE_W), .TAG_W(TAG_W), .CHAN_W(CHAN_W), .SEQ_W(SEQ_W),
    .DROP_W(DROP_W), .BLOCK_LEN(BLOCK_LEN), .DEPTH(FIFO_DEPTH)
  ) ingest_i (
    .clk(clk), .rst_n(rst_n), .stat_clr(stat_clr), .chan_id(chan_id),
    .in_valid(in_valid), .in_sample(in_sample), .in_marker(in_marker),
    .in_tag(in_tag), .occ(occ), .wr_en(wr_en), .wr_data(wr_data),
    .hdr_push(hdr_push), .hdr_word(hdr_word), .drop_cnt(drop_cnt),
    .overflow(overflow)
  );

  blkfr_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) data_q_i (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .wdata(wr_data),
    .pop(data_pop), .rdata(data_head), .count(occ)
  );

  blkfr_fifo #(.W(WORD_W), .DEPTH(HDR_DEPTH)) hdr_q_i (
    .clk(clk), .rst_n(rst_n), .push(hdr_push), .wdata(hdr_word),
    .pop(hdr_pop), .rdata(hdr_head), .count(hcount)
  );

  blkfr_egress #(.BLOCK_LEN(BLOCK_LEN), .SAMPLE_W(SAMPLE_W), .HDR_W(WORD_W)) egress_i (
    .clk(clk), .rst_n(rst_n), .hdr_avail(hcount != '0), .hdr_word(hdr_head),
    .data_avail(occ != '0), .data_word(data_head), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
    .out_last(out_last), .hdr_pop(hdr_pop), .data_pop(data_pop)
  );

  blkfr_levels #(
    .DEPTH(FIFO_DEPTH), .LOW_TH(LOW_TH), .MID_TH(MID_TH), .HIGH_TH(HIGH_TH)
  ) levels_i (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr), .occ(occ),
    .lvl_low(lvl_low), .lvl_mid(lvl_mid), .lvl_high(lvl_high), .peak(peak_occ)
  );

  AST_HDR_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_push |-> (hcount < HCW'(HDR_DEPTH)) || hdr_pop);  // R2
  AST_GAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt != $past(drop_cnt)) && (drop_cnt != '0) |-> overflow);  // R7

endmodule

// File: tb/chan_block_framer_tb.sv
module chan_block_framer_tb_top;
  localparam int SAMPLE_W = 16, TAG_W = 16, CHAN_W = 4, SEQ_W = 8, DROP_W = 8;
  localparam int BLOCK_LEN = 8, FIFO_DEPTH = 32, LOW_TH = 8, MID_TH = 16, HIGH_TH = 24;
  localparam int OFF_W = 3, WORD_W = 33, CW = 6;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0, stat_clr = 1'b0;
  logic [CHAN_W-1:0] chan_id = 4'd5;
  logic in_valid = 1'b0, in_marker = 1'b0, out_ready = 1'b0;
  logic [SAMPLE_W-1:0] in_sample = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic out_valid, out_first, out_last, overflow, lvl_low, lvl_mid, lvl_high;
  logic [WORD_W-1:0] out_data;
  logic [DROP_W-1:0] drop_cnt;
  logic [CW-1:0] peak_occ;

  always #10 clk = ~clk;  // 50 MHz

  chan_block_framer dut_i (
    .clk(clk), .rst_n(rst_n), .stat_clr(stat_clr), .chan_id(chan_id),
    .in_valid(in_valid), .in_sample(in_sample), .in_marker(in_marker), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .drop_cnt(drop_cnt),
    .overflow(overflow), .lvl_low(lvl_low), .lvl_mid(lvl_mid), .lvl_high(lvl_high),
    .peak_occ(peak_occ)
  );

  int checks = 0, errors = 0, cycles = 0, sent = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int dq[$];
  logic [WORD_W-1:0] hq[$];
  bit m_body, m_keep, m_ovf, m_seen, m_multi;
  int m_beat, m_pos, m_seq, m_seqcur, m_tagcur, m_chancur, m_off, m_dcnt, m_peak;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq.delete(); hq.delete();
      m_body = 0; m_keep = 0; m_ovf = 0; m_seen = 0; m_multi = 0;
      m_beat = 0; m_pos = 0; m_seq = 0; m_seqcur = 0; m_tagcur = 0; m_chancur = 0;
      m_off = 0; m_dcnt = 0; m_peak = 0;
    end else begin
      int occ, dbase;
      bit fire, ev, dev;
      occ = dq.size();
      ev = m_body ? (occ > 0) : (hq.size() > 0);
      fire = ev && out_ready;
      m_peak = stat_clr ? occ : ((occ > m_peak) ? occ : m_peak);
      dbase = stat_clr ? 0 : m_dcnt;
      dev = 0;
      if (in_valid) begin
        if (m_pos == 0) begin
          m_keep = (occ <= FIFO_DEPTH - BLOCK_LEN);
          m_ovf = !m_keep; dev = !m_keep;
          m_seqcur = m_seq; m_seq = (m_seq + 1) % 256;
          m_tagcur = in_tag; m_chancur = chan_id;
          m_seen = in_marker; m_off = 0; m_multi = 0;
        end else if (in_marker) begin
          if (m_seen) m_multi = 1;
          else begin m_seen = 1; m_off = m_pos; end
        end
        if (m_keep) dq.push_back(int'(in_sample));
        if (m_pos == BLOCK_LEN - 1 && m_keep)
          hq.push_back({CHAN_W'(m_chancur), SEQ_W'(m_seqcur), TAG_W'(m_tagcur),
                        OFF_W'(m_off), m_seen, m_multi});
        m_pos = (m_pos + 1) % BLOCK_LEN;
      end
      if (dev && dbase < 255) dbase++;
      m_dcnt = dbase;
      if (fire) begin
        if (m_body) begin
          void'(dq.pop_front());
          if (m_beat == BLOCK_LEN - 1) m_body = 0; else m_beat++;
        end else begin
          void'(hq.pop_front());
          m_body = 1; m_beat = 0;
        end
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int occ;
      bit ev;
      occ = dq.size();
      ev = m_body ? (occ > 0) : (hq.size() > 0);
      chk(out_valid === ev, "R10 out_valid", out_valid, ev);
      if (ev && out_valid === 1'b1) begin
        if (m_body) begin
          chk(out_data === WORD_W'(dq[0]), "R2 R5 payload", out_data, dq[0]);
          chk(out_first === 1'b0, "R2 first", out_first, 0);
          chk(out_last === (m_beat == BLOCK_LEN - 1), "R2 last", out_last, m_beat == BLOCK_LEN - 1);
        end else begin
          chk(out_data === hq[0], "R3 R4 header", out_data, hq[0]);
          chk(out_first === 1'b1, "R2 first", out_first, 1);
          chk(out_last === 1'b0, "R2 last", out_last, 0);
        end
      end
      chk(drop_cnt === DROP_W'(m_dcnt), "R6 R11 drop_cnt", drop_cnt, m_dcnt);
      chk(overflow === m_ovf, "R7 overflow", overflow, m_ovf);
      chk(lvl_low === (occ < LOW_TH), "R8 lvl_low", lvl_low, occ < LOW_TH);
      chk(lvl_mid === (occ >= MID_TH), "R8 lvl_mid", lvl_mid, occ >= MID_TH);
      chk(lvl_high === (occ >= HIGH_TH), "R8 lvl_high", lvl_high, occ >= HIGH_TH);
      chk(peak_occ === CW'(m_peak), "R9 peak", peak_occ, m_peak);
    end
  end

  task automatic drive(input bit v, input int smp, input bit mk, input bit rdy, input bit clr);
    @(negedge clk);
    in_valid = v; in_sample = SAMPLE_W'(smp); in_marker = mk;
    out_ready = rdy; stat_clr = clr; in_tag = in_tag + 1'b1;
    if (v) sent++;
  endtask

  function automatic bit mark_pat(input int b, input int p);
    case (b)
      1: return p == 0;
      2: return p == 7;
      3: return (p == 2) || (p == 5);
      4: return p == 3;
      5: return (p == 0) || (p == 7);
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    chk(drop_cnt === '0, "R1 drop_cnt", drop_cnt, 0);
    chk(overflow === 1'b0, "R1 overflow", overflow, 0);
    chk(peak_occ === '0, "R1 peak", peak_occ, 0);
    chk(lvl_low === 1'b1, "R1 lvl_low", lvl_low, 1);
    @(negedge clk); rst_n = 1'b1; cmp_on = 1'b1;

    // Marker placements with a free-flowing consumer (R4)
    for (int b = 0; b < 6; b++)
      for (int p = 0; p < BLOCK_LEN; p++) drive(1, b * 16 + p, mark_pat(b, p), 1, 0);
    repeat (60) drive(0, 0, 0, 1, 0);

    // Stalled consumer: four blocks fit, six are discarded (R5)
    for (int i = 0; i < 10 * BLOCK_LEN; i++) drive(1, 1000 + i, (i % 11) == 4, 0, 0);
    @(posedge clk); #1;
    chk(drop_cnt === DROP_W'(6), "R5 R6 discards", drop_cnt, 6);
    chk(peak_occ === CW'(FIFO_DEPTH), "R9 peak full", peak_occ, FIFO_DEPTH);
    chk(overflow === 1'b1, "R7 overflow held", overflow, 1);
    repeat (60) drive(0, 0, 0, 1, 0);
    drive(0, 0, 0, 1, 1);
    @(posedge clk); #1;
    chk(peak_occ === '0, "R9 peak cleared", peak_occ, 0);
    chk(lvl_low === 1'b1, "R8 drained", lvl_low, 1);

    // Random traffic, stalls and clears
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 4) != 0, int'($urandom), ($urandom % 6) == 0,
            ($urandom % 3) != 0, ($urandom % 200) == 0);

    // Align to a block edge, then drain
    while (sent % BLOCK_LEN != 0) drive(1, 7, 0, 1, 0);
    repeat (80) drive(0, 0, 0, 1, 0);

    // Clear coinciding with a discard, then saturation (R11, R6)
    for (int b = 0; b < 300; b++)
      for (int p = 0; p < BLOCK_LEN; p++) begin
        drive(1, b + p, 0, 0, (b == 20) && (p == 0));
        if (b == 20 && p == 0) begin
          @(posedge clk); #1;
          chk(drop_cnt === DROP_W'(1), "R11 clear with discard", drop_cnt, 1);
        end
      end
    @(posedge clk); #1;
    chk(drop_cnt === DROP_W'(255), "R6 saturation", drop_cnt, 255);
    repeat (60) drive(0, 0, 0, 1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule